// File: doc/BRIEF.md
# Counterflow Squared-Difference Correlator

This block is a linear systolic array that slides a short numeric pattern along an unbounded stream of signed text samples. For each text position it produces the sum of squared differences between the pattern and the window of text that ends at that position. A small sum marks a close match.

Pattern samples enter at the left edge and move right. Text samples enter at the right edge and move left. Both move one cell per beat, and only every other cell holds valid data, so each pattern sample meets each passing text sample in exactly one cell. The host repeats the pattern with no gap and flags its final sample. Each cell forms the difference text minus pattern and squares it. The cell adds the square to a running total, and when the flagged sample arrives it attaches the completed total to the text sample that closed the window. That result then travels left with the text sample and leaves the array together with it.

Every cell chooses one of three actions per beat, using the states of the enumeration `meet_e`:
- `MEET_NONE`: no pair is present. The total holds and the incoming result passes through.
- `MEET_ADD`: a pair is present and not flagged. The square is added to the total.
- `MEET_FLUSH`: the pair is flagged. The total plus the square is emitted and the total clears.

The state goes to `MEET_ADD` or `MEET_FLUSH` whenever both data slots of the cell are valid, and back to `MEET_NONE` otherwise. A result input and the pattern and text pass-through outputs let several arrays be chained.

Top module: `cw_sqdiff_corr`

## Requirements
- R1: A synchronous reset clears every valid bit and every running total. In the cycle after reset is released, `pat_vld_o`, `txt_vld_o` and `res_vld_o` are all 0.
- R2: The host presents pattern and text samples on the same beat parity. Neither `pat_vld_i` nor `txt_vld_i` is ever high on two consecutive beats. `res_vld_i` may be high only together with `txt_vld_i`.
- R3: Let the pattern be p0..p(K-1), with 1 <= K <= N. It is presented cyclically with no gap, and `pat_last_i` is high on p(K-1). A text sample m that leaves with a result from the array carries the value sum over j=0..K-1 of (s(m-K+1+j) - pj)^2, where the samples are signed two's complement.
- R4: Once the pattern has streamed without a gap for 2N+K text samples, every further text sample leaves with `res_vld_o` high.
- R5: A text sample that meets no flagged pattern sample leaves with `res_vld_o` and `res_o` equal to the `res_vld_i` and `res_i` it entered with.
- R6: Text samples leave at `txt_o` unchanged and in arrival order. Pattern samples and their flags leave at `pat_o` and `pat_last_o` unchanged and in arrival order.
- R7: `txt_vld_o` is never high on two consecutive beats, and neither is `pat_vld_o`.
- R8: `res_vld_o` is high only while `txt_vld_o` is high.
- R9: Full-scale inputs do not wrap. A pattern of all -2^(W-1) against text of all 2^(W-1)-1 gives K*(2^W-1)^2.
- R10: For an even N, the text enters the array one beat later than presented, so that text and pattern meet in cells rather than crossing between them. For an odd N, the text enters with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock |
| rst | input | 1 | Synchronous reset, active high |
| pat_vld_i | input | 1 | Pattern sample valid |
| pat_i | input | W | Signed pattern sample |
| pat_last_i | input | 1 | Marks the final sample of the pattern |
| txt_vld_i | input | 1 | Text sample valid |
| txt_i | input | W | Signed text sample |
| res_vld_i | input | 1 | Result valid from a downstream array |
| res_i | input | AW | Result value from a downstream array |
| pat_vld_o | output | 1 | Pattern pass-through valid |
| pat_o | output | W | Pattern pass-through sample |
| pat_last_o | output | 1 | Pattern pass-through end flag |
| txt_vld_o | output | 1 | Text pass-through valid |
| txt_o | output | W | Text pass-through sample |
| res_vld_o | output | 1 | Result valid, aligned with the text sample |
| res_o | output | AW | Squared-difference sum, AW = 2W + clog2(N+1) |

## Verification
The bench builds the array with N = 6 and W = 8. An even N switches on the one-beat text delay, and the 19-bit accumulator has little headroom over six full-scale squares. Pattern lengths of 6, 4 and 1 are used:
- With 4, a text sample crosses two flagged samples, so later results overwrite earlier ones.
- With 1, every meeting flushes.

A run with no pattern at all shows the result input passing straight through.

// File: rtl/cw_pkg.sv
package cw_pkg;

    // Per-beat action chosen by an accumulating cell.
    typedef enum logic [1:0] {
        MEET_NONE  = 2'd0,
        MEET_ADD   = 2'd1,
        MEET_FLUSH = 2'd2
    } meet_e;

endpackage

// File: rtl/cw_text_skew.sv
module cw_text_skew #(
    parameter int W     = 8,
    parameter int AW    = 20,
    parameter int DEPTH = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sv_i,
    input  logic signed [W-1:0]  s_i,
    input  logic                 rv_i,
    input  logic        [AW-1:0] r_i,
    output logic                 sv_o,
    output logic signed [W-1:0]  s_o,
    output logic                 rv_o,
    output logic        [AW-1:0] r_o
);

    generate
        if (DEPTH == 0) begin : g_direct
            assign sv_o = sv_i;
            assign s_o  = s_i;
            assign rv_o = rv_i;
            assign r_o  = r_i;
        end else begin : g_delay
            logic                 sv_q;
            logic signed [W-1:0]  s_q;
            logic                 rv_q;
            logic        [AW-1:0] r_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    sv_q <= 1'b0;
                    s_q  <= '0;
                    rv_q <= 1'b0;
                    r_q  <= '0;
                end else begin
                    sv_q <= sv_i;
                    s_q  <= s_i;
                    rv_q <= rv_i;
                    r_q  <= r_i;
                end
            end

            assign sv_o = sv_q;
            assign s_o  = s_q;
            assign rv_o = rv_q;
            assign r_o  = r_q;
        end
    endgenerate

endmodule

// File: rtl/cw_diff_cell.sv
module cw_diff_cell #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    // pattern slot, fed from the left neighbour
    input  logic                pv_i,
    input  logic signed [W-1:0] p_i,
    input  logic                pe_i,
    // text slot, fed from the right neighbour
    input  logic                sv_i,
    input  logic signed [W-1:0] s_i,
    output logic                pv_q,
    output logic signed [W-1:0] p_q,
    output logic                pe_q,
    output logic                sv_q,
    output logic signed [W-1:0] s_q,
    output logic signed [W:0]   d_o,
    output logic                meet_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pv_q <= 1'b0;
            p_q  <= '0;
            pe_q <= 1'b0;
            sv_q <= 1'b0;
            s_q  <= '0;
        end else begin
            pv_q <= pv_i;
            p_q  <= p_i;
            pe_q <= pe_i & pv_i;
            sv_q <= sv_i;
            s_q  <= s_i;
        end
    end

    // One guard bit: the difference of two W-bit signed values fits in W+1.
    assign d_o    = {s_q[W-1], s_q} - {p_q[W-1], p_q};
    assign meet_o = pv_q & sv_q;

endmodule

// File: rtl/cw_acc_cell.sv
module cw_acc_cell
    import cw_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 meet_i,
    input  logic                 last_i,
    input  logic signed [W:0]    d_i,
    // result slot travelling with the text, from the right neighbour
    input  logic                 rv_i,
    input  logic        [AW-1:0] r_i,
    output logic                 rv_o,
    output logic        [AW-1:0] r_o
);

    localparam int SQW = 2 * W;

    meet_e                act;
    logic        [W:0]    mag;
    logic      [2*W+1:0]  sq_full;
    logic        [AW-1:0] sq_ext;
    logic        [AW-1:0] sum;
    logic        [AW-1:0] tot_q;
    logic                 rv_q;
    logic        [AW-1:0] r_q;

    always_comb begin
        if (!meet_i) begin
            act = MEET_NONE;
        end else if (last_i) begin
            act = MEET_FLUSH;
        end else begin
            act = MEET_ADD;
        end
    end

    always_comb begin
        mag     = d_i[W] ? $unsigned(-d_i) : $unsigned(d_i);
        sq_full = {{(W+1){1'b0}}, mag} * {{(W+1){1'b0}}, mag};
        sq_ext  = {{(AW-SQW){1'b0}}, sq_full[SQW-1:0]};
        sum     = tot_q + sq_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tot_q <= '0;
            rv_q  <= 1'b0;
            r_q   <= '0;
        end else begin
            rv_q <= rv_i;
            r_q  <= r_i;
            unique case (act)
                MEET_NONE:  tot_q <= tot_q;
                MEET_ADD:   tot_q <= sum;
                MEET_FLUSH: tot_q <= '0;
                default:    tot_q <= tot_q;
            endcase
        end
    end

    always_comb begin
        unique case (act)
            MEET_FLUSH: begin
                rv_o = 1'b1;
                r_o  = sum;
            end
            MEET_NONE, MEET_ADD: begin
                rv_o = rv_q;
                r_o  = r_q;
            end
            default: begin
                rv_o = rv_q;
                r_o  = r_q;
            end
        endcase
    end

endmodule

// File: rtl/cw_sqdiff_corr.sv
module cw_sqdiff_corr #(
    parameter  int N  = 8,
    parameter  int W  = 8,
    localparam int AW = 2 * W + $clog2(N + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pat_vld_i,
    input  logic signed [W-1:0]  pat_i,
    input  logic                 pat_last_i,
    input  logic                 txt_vld_i,
    input  logic signed [W-1:0]  txt_i,
    input  logic                 res_vld_i,
    input  logic        [AW-1:0] res_i,
    output logic                 pat_vld_o,
    output logic signed [W-1:0]  pat_o,
    output logic                 pat_last_o,
    output logic                 txt_vld_o,
    output logic signed [W-1:0]  txt_o,
    output logic                 res_vld_o,
    output logic        [AW-1:0] res_o
);

    // Text must meet the pattern on the same cell parity.
    localparam int SKEW = (N % 2 == 0) ? 1 : 0;

    // pattern chain: index c feeds cell c, index N is the right edge
    logic                 pv_w [0:N];
    logic signed [W-1:0]  p_w  [0:N];
    logic                 pe_w [0:N];
    // text chain: index c is cell c's slot, index N is the skewed input
    logic                 sv_w [0:N];
    logic signed [W-1:0]  s_w  [0:N];
    // result chain: index c is what leaves cell c to the left
    logic                 rv_w [0:N];
    logic        [AW-1:0] r_w  [0:N];

    logic                 txt_vld_q;
    logic signed [W-1:0]  txt_q;
    logic                 res_vld_q;
    logic        [AW-1:0] res_q;

    assign pv_w[0] = pat_vld_i;
    assign p_w[0]  = pat_i;
    assign pe_w[0] = pat_last_i;

    cw_text_skew #(
        .W     (W),
        .AW    (AW),
        .DEPTH (SKEW)
    ) skew_i (
        .clk  (clk),
        .rst  (rst),
        .sv_i (txt_vld_i),
        .s_i  (txt_i),
        .rv_i (res_vld_i),
        .r_i  (res_i),
        .sv_o (sv_w[N]),
        .s_o  (s_w[N]),
        .rv_o (rv_w[N]),
        .r_o  (r_w[N])
    );

    generate
        for (genvar c = 0; c < N; c++) begin : g_cell
            logic signed [W:0] d;
            logic              meet;

            cw_diff_cell #(
                .W (W)
            ) diff_i (
                .clk    (clk),
                .rst    (rst),
                .pv_i   (pv_w[c]),
                .p_i    (p_w[c]),
                .pe_i   (pe_w[c]),
                .sv_i   (sv_w[c+1]),
                .s_i    (s_w[c+1]),
                .pv_q   (pv_w[c+1]),
                .p_q    (p_w[c+1]),
                .pe_q   (pe_w[c+1]),
                .sv_q   (sv_w[c]),
                .s_q    (s_w[c]),
                .d_o    (d),
                .meet_o (meet)
            );

            cw_acc_cell #(
                .W  (W),
                .AW (AW)
            ) acc_i (
                .clk    (clk),
                .rst    (rst),
                .meet_i (meet),
                .last_i (pe_w[c+1]),
                .d_i    (d),
                .rv_i   (rv_w[c+1]),
                .r_i    (r_w[c+1]),
                .rv_o   (rv_w[c]),
                .r_o    (r_w[c])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            txt_vld_q <= 1'b0;
            txt_q     <= '0;
            res_vld_q <= 1'b0;
            res_q     <= '0;
        end else begin
            txt_vld_q <= sv_w[0];
            txt_q     <= s_w[0];
            res_vld_q <= rv_w[0] & sv_w[0];
            res_q     <= r_w[0];
        end
    end

    assign pat_vld_o  = pv_w[N];
    assign pat_o      = p_w[N];
    assign pat_last_o = pe_w[N];
    assign txt_vld_o  = txt_vld_q;
    assign txt_o      = txt_q;
    assign res_vld_o  = res_vld_q;
    assign res_o      = res_q;

endmodule

// File: rtl/cw_sqdiff_corr_chk.sv
module cw_sqdiff_corr_chk #(
    parameter  int N  = 8,
    parameter  int W  = 8,
    localparam int AW = 2 * W + $clog2(N + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 pat_vld_i,
    input logic signed [W-1:0]  pat_i,
    input logic                 pat_last_i,
    input logic                 txt_vld_i,
    input logic signed [W-1:0]  txt_i,
    input logic                 res_vld_i,
    input logic        [AW-1:0] res_i,
    input logic                 pat_vld_o,
    input logic signed [W-1:0]  pat_o,
    input logic                 pat_last_o,
    input logic                 txt_vld_o,
    input logic signed [W-1:0]  txt_o,
    input logic                 res_vld_o,
    input logic        [AW-1:0] res_o
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!pat_vld_o && !txt_vld_o && !res_vld_o));

    p_pat_in_gap_r2: assert property (@(posedge clk) disable iff (rst)
        pat_vld_i |=> !pat_vld_i);

    p_txt_in_gap_r2: assert property (@(posedge clk) disable iff (rst)
        txt_vld_i |=> !txt_vld_i);

    p_res_in_with_txt_r2: assert property (@(posedge clk) disable iff (rst)
        res_vld_i |-> txt_vld_i);

    p_txt_out_gap_r7: assert property (@(posedge clk) disable iff (rst)
        txt_vld_o |=> !txt_vld_o);

    p_pat_out_gap_r7: assert property (@(posedge clk) disable iff (rst)
        pat_vld_o |=> !pat_vld_o);

    p_res_rides_txt_r8: assert property (@(posedge clk) disable iff (rst)
        res_vld_o |-> txt_vld_o);

endmodule

bind cw_sqdiff_corr cw_sqdiff_corr_chk #(.N(N), .W(W)) chk_i (.*);

// File: tb/cw_sqdiff_corr_tb.sv
module cw_sqdiff_corr_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 6;
    localparam int W  = 8;
    localparam int AW = 2 * W + $clog2(N + 1);
    localparam int MAXT = 300;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 pat_vld_i = 1'b0;
    logic signed [W-1:0]  pat_i = '0;
    logic                 pat_last_i = 1'b0;
    logic                 txt_vld_i = 1'b0;
    logic signed [W-1:0]  txt_i = '0;
    logic                 res_vld_i = 1'b0;
    logic        [AW-1:0] res_i = '0;
    logic                 pat_vld_o;
    logic signed [W-1:0]  pat_o;
    logic                 pat_last_o;
    logic                 txt_vld_o;
    logic signed [W-1:0]  txt_o;
    logic                 res_vld_o;
    logic        [AW-1:0] res_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int pat [0:N-1];
    int txt [0:MAXT-1];
    int rin [0:MAXT-1];
    bit rinv[0:MAXT-1];

    always #(CLK_PERIOD / 2) clk = ~clk;

    cw_sqdiff_corr #(.N(N), .W(W)) dut_i (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint window_sum(input int m, input int k);
        longint acc = 0;
        for (int j = 0; j < k; j++) begin
            longint d = longint'(txt[m - k + 1 + j]) - longint'(pat[j]);
            acc += d * d;
        end
        return acc;
    endfunction

    // Stream nt text samples against a k-long pattern (or no pattern) and
    // compare every output against values computed here.
    task automatic run_phase(input int k, input int nt, input bit use_pat, input string tag);
        int  beats = 2 * nt + 4 * N + 12;
        int  warm  = 2 * N + k;
        int  m = 0;
        int  pidx = 0;
        bit  prev_t = 1'b0;
        bit  prev_p = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!pat_vld_o && !txt_vld_o && !res_vld_o, "R1 valids low after reset",
              {pat_vld_o, txt_vld_o, res_vld_o}, 0);
        for (int b = 0; b < beats; b++) begin
            // sample previous beat's outputs
            if (txt_vld_o) begin
                check(int'(txt_o) == txt[m], "R6 text pass-through", int'(txt_o), txt[m]);
                if (use_pat && m >= warm) begin
                    check(res_vld_o, "R4 result present", res_vld_o, 1);
                    check(longint'(res_o) == window_sum(m, k), {"R3 window sum ", tag},
                          longint'(res_o), window_sum(m, k));
                end
                if (!use_pat) begin
                    check(res_vld_o == rinv[m] && (!rinv[m] || int'(res_o) == rin[m]),
                          "R5 result input passes", int'(res_o), rin[m]);
                end
                check(!prev_t, "R7 text out alternation", prev_t, 0);
                m++;
            end else begin
                check(!res_vld_o, "R8 result without text", res_vld_o, 0);
            end
            if (pat_vld_o) begin
                check(int'(pat_o) == pat[pidx % k] && pat_last_o == (pidx % k == k - 1),
                      "R6 pattern pass-through", int'(pat_o), pat[pidx % k]);
                check(!prev_p, "R7 pattern out alternation", prev_p, 0);
                pidx++;
            end
            prev_t = txt_vld_o;
            prev_p = pat_vld_o;
            // drive next beat
            if (b % 2 == 0) begin
                pat_vld_i  = use_pat;
                pat_i      = W'(pat[(b / 2) % k]);
                pat_last_i = use_pat && ((b / 2) % k == k - 1);
                txt_vld_i  = (b / 2 < nt);
                txt_i      = (b / 2 < nt) ? W'(txt[b / 2]) : '0;
                res_vld_i  = (b / 2 < nt) && !use_pat && rinv[b / 2];
                res_i      = (b / 2 < nt) ? AW'(rin[b / 2]) : '0;
            end else begin
                pat_vld_i  = 1'b0;
                pat_last_i = 1'b0;
                txt_vld_i  = 1'b0;
                res_vld_i  = 1'b0;
            end
            @(negedge clk);
        end
        check(m == nt, {"R6 text count ", tag}, m, nt);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < MAXT; i++) begin
            rin[i]  = 0;
            rinv[i] = 1'b0;
        end

        // R3/R4/R10: random data, pattern as long as the array
        for (int j = 0; j < N; j++) pat[j] = int'($urandom_range(255)) - 128;
        for (int i = 0; i < MAXT; i++) txt[i] = int'($urandom_range(255)) - 128;
        run_phase(N, 120, 1'b1, "K=N");

        // R3: shorter pattern, text crosses two flags
        for (int j = 0; j < N; j++) pat[j] = int'($urandom_range(255)) - 128;
        run_phase(4, 100, 1'b1, "K=4");

        // R3: single-sample pattern, every meeting flushes
        run_phase(1, 60, 1'b1, "K=1");

        // R9: full-scale differences must not wrap
        for (int j = 0; j < N; j++) pat[j] = -128;
        for (int i = 0; i < MAXT; i++) txt[i] = 127;
        run_phase(N, 40, 1'b1, "full scale");

        // R3: identical streams give zero
        for (int j = 0; j < N; j++) pat[j] = 5;
        for (int i = 0; i < MAXT; i++) txt[i] = 5;
        run_phase(N, 40, 1'b1, "zero");

        // R5: no pattern, result input rides through untouched
        for (int i = 0; i < MAXT; i++) begin
            txt[i]  = int'($urandom_range(255)) - 128;
            rin[i]  = int'($urandom_range(400000));
            rinv[i] = ($urandom_range(3) != 0);
        end
        for (int j = 0; j < N; j++) pat[j] = 0;
        run_phase(N, 50, 1'b0, "no pattern");

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule